// File: doc/BRIEF.md
# Single-Wire Slave Bit Engine

This block is the bit-level front end of a slave on an open-drain, single-wire bus. The bus idles high, and the master starts every exchange by pulling it low. The block synchronizes and glitch-filters the line, then measures each low period in system clock cycles. A long low period is a link reset, and the block answers it with a presence pulse. A short low period is a one-bit time slot. In a write slot the block decides the bit from whether the line was still low at the sample point. In a read slot it either leaves the line alone (a one) or holds it low for a fixed window (a zero).

The block runs at two speeds. It starts at standard speed. Overdrive begins only when the layer above pulses `od_enter`, and overdrive timings are the standard timings divided by `OD_DIV`. The width of each reset pulse then decides the speed. A very long reset always returns the link to standard speed. A short reset in overdrive keeps overdrive. A middle-length reset in overdrive falls back to standard speed and raises `spd_undef`. Towards the byte layer the block delivers received bytes with a one-cycle valid strobe, takes transmit bytes with a one-cycle request strobe, and reports each reset with a one-cycle strobe.

Top module: `swire_slave_phy`

## Requirements
- R1: After reset `bus_pd_n` is 1, `od_mode` is 0, `spd_undef` is 0, and `rx_valid`, `tx_req` and `rst_seen` are 0. The block never pulls the line while idle.
- R2: A filtered low period of at least STD_RST cycles (OD_RST in overdrive) is a reset. `rst_seen` pulses for one cycle after the line is released. A shorter low period is a bit slot and produces no `rst_seen`.
- R3: After a reset, the block waits PWAIT cycles and then drives `bus_pd_n` low for exactly PLOW cycles as a presence pulse. Both values use the speed chosen by that reset: the STD_ values at standard speed, and the STD_ values divided by OD_DIV in overdrive.
- R4: In a write slot with `rd_mode`=0, a low period of at least SAMPLE cycles gives bit 0 and a shorter one gives bit 1. Bits arrive LSB first. After the eighth slot, `rx_valid` pulses for one cycle with the byte on `rx_byte`.
- R5: In a read slot with `rd_mode`=1, the first slot of a byte latches `tx_byte` and pulses `tx_req`. A 0 bit pulls the line low for RDHOLD cycles from the detected falling edge. A 1 bit leaves the line undriven. Bits go out LSB first.
- R6: A pulse on `od_enter` sets `od_mode` and clears `spd_undef`. While `od_mode` is 1, every timing is the standard value divided by OD_DIV.
- R7: A reset low period of at least RST_LONG cycles clears `od_mode` and `spd_undef`, whatever the speed was before.
- R8: In overdrive, a reset low period of at most OD_KEEP cycles keeps `od_mode` at 1.
- R9: In overdrive, a reset low period above OD_KEEP and below RST_LONG clears `od_mode` and sets `spd_undef`. The next reset of another kind clears `spd_undef`.
- R10: Falling edges that come during the presence wait or during the REC recovery cycles after presence contribute no bit. A reset discards any partial byte.
- R11: Low pulses shorter than FILT clock cycles are filtered out and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw bus level, asynchronous |
| od_enter | input | 1 | One-cycle command to switch to overdrive |
| rd_mode | input | 1 | 1: coming slots are read slots; 0: write slots |
| tx_byte | input | 8 | Byte to return in read slots |
| bus_pd_n | output | 1 | Active-low pull-down enable for the bus |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| rx_byte | output | 8 | Last received byte |
| tx_req | output | 1 | One-cycle strobe: `tx_byte` was taken |
| rst_seen | output | 1 | One-cycle strobe: a reset pulse ended |
| od_mode | output | 1 | 1 while at overdrive speed |
| spd_undef | output | 1 | Last reset was middle-length in overdrive |

## Verification
The bench builds the block with short timings: FILT=3, STD_SAMPLE=80, STD_RDHOLD=96, STD_RST=240, OD_RST=32, OD_KEEP=160, RST_LONG=960, STD_PWAIT=64, STD_PLOW=240, STD_REC=64 and OD_DIV=8. With these values the three reset bands and both speeds take only a few hundred cycles each. Random bytes and random reset widths can therefore be mixed freely. The directed cases still sit only a few cycles from every threshold, including slots that start inside recovery and glitches just under the filter length.

// File: rtl/swire_slave_phy.sv
module swire_slave_phy #(
  parameter int FILT       = 3,
  parameter int STD_SAMPLE = 3750,
  parameter int STD_RDHOLD = 3750,
  parameter int STD_RST    = 15000,
  parameter int OD_RST     = 2000,
  parameter int OD_KEEP    = 10000,
  parameter int RST_LONG   = 60000,
  parameter int STD_PWAIT  = 3750,
  parameter int STD_PLOW   = 15000,
  parameter int STD_REC    = 7500,
  parameter int OD_DIV     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_in,
  input  logic       od_enter,
  input  logic       rd_mode,
  input  logic [7:0] tx_byte,
  output logic       bus_pd_n,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       tx_req,
  output logic       rst_seen,
  output logic       od_mode,
  output logic       spd_undef
);

  localparam int CW        = $clog2(RST_LONG + 1);
  localparam int OD_SAMPLE = STD_SAMPLE / OD_DIV;
  localparam int OD_RDHOLD = STD_RDHOLD / OD_DIV;
  localparam int OD_PWAIT  = STD_PWAIT / OD_DIV;
  localparam int OD_PLOW   = STD_PLOW / OD_DIV;
  localparam int OD_REC    = STD_REC / OD_DIV;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_PWAIT, S_PLOW, S_REC} st_t;

  st_t st;
  logic [1:0]      sync;
  logic [FILT-1:0] fsr;
  logic            filt, filt_q;
  logic [CW-1:0]   lowcnt, tmr;
  logic [2:0]      bitcnt;
  logic [6:0]      rx_sr;
  logic [7:0]      tx_sr;
  logic            live, slot_rd, drv0;

  wire fall = filt_q & ~filt;
  wire rise = ~filt_q & filt;

  wire [CW-1:0] t_sample = od_mode ? CW'(OD_SAMPLE) : CW'(STD_SAMPLE);
  wire [CW-1:0] t_rdhold = od_mode ? CW'(OD_RDHOLD) : CW'(STD_RDHOLD);
  wire [CW-1:0] t_rst    = od_mode ? CW'(OD_RST)    : CW'(STD_RST);
  wire [CW-1:0] t_pwait  = od_mode ? CW'(OD_PWAIT)  : CW'(STD_PWAIT);
  wire [CW-1:0] t_plow   = od_mode ? CW'(OD_PLOW)   : CW'(STD_PLOW);
  wire [CW-1:0] t_rec    = od_mode ? CW'(OD_REC)    : CW'(STD_REC);

  wire tx_bit  = (bitcnt == 3'd0) ? tx_byte[0] : tx_sr[0];
  wire wr_bit  = lowcnt < t_sample;

  assign bus_pd_n = ~((st == S_PLOW) | ((st == S_LOW) & drv0 & (lowcnt < t_rdhold)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      fsr    <= '1;
      filt   <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      sync   <= {sync[0], bus_in};
      fsr    <= (fsr << 1) | FILT'(sync[1]);
      filt_q <= filt;
      if (&fsr)       filt <= 1'b1;
      else if (~|fsr) filt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lowcnt    <= '0;
      tmr       <= '0;
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      tx_req    <= 1'b0;
      rst_seen  <= 1'b0;
      od_mode   <= 1'b0;
      spd_undef <= 1'b0;
      live      <= 1'b0;
      slot_rd   <= 1'b0;
      drv0      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      rst_seen <= 1'b0;
      case (st)
        S_IDLE: if (fall) begin
          st      <= S_LOW;
          lowcnt  <= CW'(1);
          live    <= 1'b1;
          slot_rd <= rd_mode;
          drv0    <= rd_mode & ~tx_bit;
          if (rd_mode && bitcnt == 3'd0) begin
            tx_sr  <= tx_byte;
            tx_req <= 1'b1;
          end
        end
        S_LOW: begin
          if (lowcnt < CW'(RST_LONG)) lowcnt <= lowcnt + 1'b1;
          if (rise) begin
            drv0 <= 1'b0;
            if (lowcnt >= t_rst) begin
              rst_seen <= 1'b1;
              bitcnt   <= '0;
              st       <= S_PWAIT;
              tmr      <= '0;
              if (lowcnt >= CW'(RST_LONG)) begin
                od_mode   <= 1'b0;
                spd_undef <= 1'b0;
              end else if (od_mode && lowcnt <= CW'(OD_KEEP)) begin
                spd_undef <= 1'b0;
              end else if (od_mode) begin
                od_mode   <= 1'b0;
                spd_undef <= 1'b1;
              end else begin
                spd_undef <= 1'b0;
              end
            end else begin
              st <= S_IDLE;
              if (live) begin
                bitcnt <= bitcnt + 1'b1;
                if (slot_rd) begin
                  tx_sr <= tx_sr >> 1;
                end else begin
                  rx_sr <= {wr_bit, rx_sr[6:1]};
                  if (bitcnt == 3'd7) begin
                    rx_byte  <= {wr_bit, rx_sr};
                    rx_valid <= 1'b1;
                  end
                end
              end
            end
          end
        end
        S_PWAIT: begin
          tmr <= tmr + 1'b1;
          if (fall) begin
            st <= S_LOW; lowcnt <= CW'(1); live <= 1'b0; drv0 <= 1'b0; slot_rd <= 1'b0;
          end else if (tmr == t_pwait - 1'b1) begin
            st <= S_PLOW; tmr <= '0;
          end
        end
        S_PLOW: begin
          tmr <= tmr + 1'b1;
          if (tmr == t_plow - 1'b1) begin
            st <= S_REC; tmr <= '0;
          end
        end
        S_REC: begin
          tmr <= tmr + 1'b1;
          if (fall) begin
            st <= S_LOW; lowcnt <= CW'(1); live <= 1'b0; drv0 <= 1'b0; slot_rd <= 1'b0;
          end else if (tmr == t_rec - 1'b1) begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (od_enter) begin
        od_mode   <= 1'b1;
        spd_undef <= 1'b0;
      end
    end
  end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> bus_pd_n);
  assert_rst_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |=> !rst_seen);
  assert_rx_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_txreq_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(rd_mode));
  assert_undef_std_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spd_undef |-> !od_mode);

endmodule

// File: tb/swire_slave_phy_tb_top.sv
module swire_slave_phy_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, m_low = 1'b0, od_enter = 1'b0, rd_mode = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic bus_pd_n, rx_valid, tx_req, rst_seen, od_mode, spd_undef;
  logic [7:0] rx_byte;
  wire bus_line = ~m_low & bus_pd_n;

  int checks = 0, failures = 0, rx_cnt = 0, rst_cnt = 0, txr_cnt = 0;
  int pd_run = 0, last_pd = 0;
  logic [7:0] rx_last = 8'h00;
  bit cur_od = 0, cur_und = 0;

  always #4 clk = ~clk;

  swire_slave_phy #(.FILT(3), .STD_SAMPLE(80), .STD_RDHOLD(96), .STD_RST(240), .OD_RST(32),
    .OD_KEEP(160), .RST_LONG(960), .STD_PWAIT(64), .STD_PLOW(240), .STD_REC(64), .OD_DIV(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_line), .od_enter(od_enter), .rd_mode(rd_mode),
    .tx_byte(tx_byte), .bus_pd_n(bus_pd_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .rst_seen(rst_seen), .od_mode(od_mode), .spd_undef(spd_undef));

  always @(negedge clk) begin
    if (rx_valid) begin rx_last = rx_byte; rx_cnt++; end
    if (rst_seen) rst_cnt++;
    if (tx_req) txr_cnt++;
    if (!bus_pd_n && !m_low) pd_run++;
    else if (pd_run != 0) begin last_pd = pd_run; pd_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_od(input bit od, input int len);
    if (len >= 960) return 1'b0;
    return od && len <= 160;
  endfunction

  function automatic bit exp_und(input bit od, input int len);
    return od && len > 160 && len < 960;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
    while (!bus_line) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk) m_low = 1'b1;
    repeat (n) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic slot_write(input bit b);
    low_pulse(b ? 5 : (cur_od ? 20 : 150));
    settle();
  endtask

  task automatic slot_read(output bit b);
    int ml = cur_od ? 8 : 10;
    int sp = cur_od ? 11 : 30;
    @(negedge clk) m_low = 1'b1;
    for (int i = 1; i <= sp; i++) begin
      @(negedge clk);
      if (i == ml) m_low = 1'b0;
    end
    b = bus_line;
    settle();
  endtask

  task automatic write_byte(input logic [7:0] v, input string req);
    int c0 = rx_cnt;
    rd_mode = 1'b0;
    for (int i = 0; i < 8; i++) slot_write(v[i]);
    chk(rx_cnt == c0 + 1, req, rx_cnt - c0, 1);
    chk(rx_last == v, req, rx_last, v);
  endtask

  task automatic read_byte(input logic [7:0] v, input string req);
    logic [7:0] got;
    bit b;
    int t0 = txr_cnt;
    rd_mode = 1'b1;
    tx_byte = v;
    for (int i = 0; i < 8; i++) begin slot_read(b); got[i] = b; end
    rd_mode = 1'b0;
    chk(got == v, req, got, v);
    chk(txr_cnt == t0 + 1, req, txr_cnt - t0, 1);
  endtask

  task automatic do_reset(input int len, input string req);
    int r0 = rst_cnt;
    bit nod = exp_od(cur_od, len);
    bit nund = exp_und(cur_od, len);
    low_pulse(len);
    repeat (450) @(negedge clk);
    cur_od = nod; cur_und = nund;
    chk(rst_cnt == r0 + 1, req, rst_cnt - r0, 1);
    chk(last_pd == (nod ? 30 : 240), req, last_pd, nod ? 30 : 240);
    chk(od_mode == nod, req, od_mode, nod);
    chk(spd_undef == nund, req, spd_undef, nund);
  endtask

  task automatic go_od();
    @(negedge clk) od_enter = 1'b1;
    @(negedge clk) od_enter = 1'b0;
    cur_od = 1; cur_und = 0;
    chk(od_mode == 1'b1, "R6", od_mode, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(bus_pd_n == 1'b1, "R1", bus_pd_n, 1);
    chk(od_mode == 1'b0 && spd_undef == 1'b0, "R1", od_mode, 0);
    chk(rx_cnt == 0 && txr_cnt == 0 && rst_cnt == 0, "R1", rx_cnt + txr_cnt + rst_cnt, 0);

    do_reset(300, "R2 R3");
    write_byte(8'hA5, "R4");
    write_byte(8'h01, "R4");
    read_byte(8'h3C, "R5");

    // R2: 200-cycle low at standard speed is a bit slot, not a reset
    r0 = rst_cnt;
    low_pulse(200); settle();
    chk(rst_cnt == r0, "R2", rst_cnt - r0, 0);
    // R10: partial byte dropped by reset
    slot_write(1'b1); slot_write(1'b0);
    do_reset(500, "R10");
    write_byte(8'h96, "R10");

    // R10: slot inside recovery ignored
    low_pulse(300);
    while (bus_pd_n) @(negedge clk);
    while (!bus_pd_n) @(negedge clk);
    repeat (10) @(negedge clk);
    low_pulse(5); settle();
    repeat (100) @(negedge clk);
    write_byte(8'h4E, "R10");

    // R11: glitches below filter length
    low_pulse(1); repeat (10) @(negedge clk);
    low_pulse(2); repeat (10) @(negedge clk);
    chk(rst_cnt >= 0 && bus_pd_n, "R11", bus_pd_n, 1);
    write_byte(8'hC3, "R11");

    go_od();
    do_reset(100, "R8");
    write_byte(8'h5A, "R6");
    read_byte(8'hE1, "R6 R5");
    do_reset(36, "R8 R2");
    r0 = rst_cnt;
    low_pulse(28); settle();
    chk(rst_cnt == r0, "R2", rst_cnt - r0, 0);
    do_reset(156, "R8");
    do_reset(164, "R9");
    do_reset(300, "R9");
    go_od();
    do_reset(1000, "R7");
    go_od();
    do_reset(956, "R9");
    do_reset(964, "R7");

    for (int it = 0; it < 24; it++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] v = 8'($urandom);
      if (op == 0) write_byte(v, "R4");
      else if (op == 1) read_byte(v, "R5");
      else if (op == 2) begin
        if ($urandom_range(0, 1) == 1 && !cur_od) go_od();
        write_byte(v, "R6");
      end else begin
        int len;
        if (cur_od) begin
          case ($urandom_range(0, 2))
            0: len = $urandom_range(36, 156);
            1: len = $urandom_range(164, 956);
            default: len = $urandom_range(964, 1100);
          endcase
        end else len = $urandom_range(244, 1100);
        do_reset(len, cur_od ? "R9" : "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule